// File: doc/BRIEF.md
# Segment Selector Load and Interrupt Shadow Unit

This block sits at the retire stage of a processor core and owns the six segment selector registers. Each retiring instruction that touches a segment register presents one request. The request is a selector load, a selector read into a general register, or a memory reference made through a segment. The unit decides whether the instruction faults with an invalid-opcode fault or a general-protection fault, or whether it completes. It then updates the selector storage and a per-segment null flag. Descriptor table fetch and descriptor checking happen elsewhere, and their result arrives on a single descriptor-valid input.

A committed stack-segment load opens a one-instruction interrupt shadow. While the shadow is open, pending interrupts and instruction-breakpoint matches are not accepted. The shadow closes on the next retire pulse, whatever that instruction is, so a second stack-segment load right behind the first does not extend it. Null selectors may be placed in the data segments without a fault. The fault is deferred to the first memory reference made through such a segment, and that reference is then blocked.

Encodings: operation `op_i` 0 = no segment operation, 1 = load, 2 = read, 3 = memory reference. Segment id `seg_i` 0 = ES, 1 = CS, 2 = SS, 3 = DS, 4 = FS, 5 = GS; ids 6 and 7 do not exist. All result outputs are registered and appear after the clock edge on which `retire_i` is sampled high.

Top module: `seg_load_unit`

## Requirements
- R1: A load (op 1) naming CS (id 1) gives a `fault_ud_o` pulse, no commit, and CS keeps its selector.
- R2: Any load, read or memory reference naming id 6 or 7 gives a `fault_ud_o` pulse and no other result pulse.
- R3: A selector 0x0000 to 0x0003 is null. It commits to ES, DS, FS or GS with no fault and sets that segment's null flag. Selector 0x0004 is not null.
- R4: A null selector loaded into SS (id 2) gives `fault_gp_o` and no commit, and SS keeps its old selector.
- R5: A non-null load commits only when `desc_ok_i` is 1, which clears the null flag. Otherwise it gives `fault_gp_o` and leaves the old selector in place.
- R6: A memory reference (op 3) through a segment whose null flag is set gives `fault_gp_o` with `mem_req_o` low. Through a non-null segment it gives `mem_req_o` high with no fault.
- R7: A read (op 2) pulses `rd_valid_o` and returns the selector on `rd_data_o[15:0]` with all upper bits zero.
- R8: After reset every selector reads 0, every null flag is set, and the shadow is closed.
- R9: A committed SS load opens the shadow (`shadow_o` = 1). While it is open, `irq_take_o` stays low even when `irq_req_i` is high. The next retire pulse closes it.
- R10: An SS load that retires while the shadow is open does not reopen it, so an interrupt can be taken before the third instruction.
- R11: While the shadow is open, `bkpt_hit_i` does not produce `bkpt_take_o`.
- R12: Each result pulse (`fault_ud_o`, `fault_gp_o`, `commit_o`, `rd_valid_o`, `mem_req_o`) lasts one cycle, follows a retire, and at most one of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_i | input | 1 | Instruction retires this cycle |
| op_i | input | 2 | Segment operation of the retiring instruction |
| seg_i | input | 3 | Target segment id |
| sel_i | input | 16 | Selector value for a load |
| desc_ok_i | input | 1 | Descriptor checks passed for this selector |
| irq_req_i | input | 1 | Pending interrupt |
| bkpt_hit_i | input | 1 | Instruction-breakpoint match |
| fault_ud_o | output | 1 | Invalid-opcode fault pulse |
| fault_gp_o | output | 1 | General-protection fault pulse |
| commit_o | output | 1 | Selector load committed |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 64 | Zero-extended selector |
| mem_req_o | output | 1 | Memory reference allowed |
| irq_take_o | output | 1 | Interrupt accepted |
| bkpt_take_o | output | 1 | Breakpoint accepted |
| shadow_o | output | 1 | Interrupt shadow is open |

## Verification
The assertions assume that `op_i`, `seg_i`, `sel_i` and `desc_ok_i` are meaningful only in cycles where `retire_i` is high. They also assume that `irq_req_i` and `bkpt_hit_i` are level requests that may be held across many cycles. Reset is assumed to be held for at least one edge before any retire. The bench drives every input on the falling edge and changes request fields only together with `retire_i`. It always leaves at least one idle edge between retires. It holds reset for several edges at the start. As a result, every shadow window it checks is bounded by retire pulses it controls.

// File: rtl/seg_pkg.sv
package seg_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LOAD = 2'd1,
    OP_READ = 2'd2,
    OP_MEM  = 2'd3
  } seg_op_e;

  typedef enum logic [2:0] {
    SEG_ES = 3'd0,
    SEG_CS = 3'd1,
    SEG_SS = 3'd2,
    SEG_DS = 3'd3,
    SEG_FS = 3'd4,
    SEG_GS = 3'd5
  } seg_id_e;

  // Outcome of one retiring request, before registering.
  typedef struct packed {
    logic ud;         // invalid opcode
    logic gp;         // protection fault
    logic commit;     // write selector
    logic rd;         // read selector out
    logic mem;        // memory access allowed
    logic ss_commit;  // committed stack-segment load
    logic is_null;    // committed selector is null
  } verdict_t;

endpackage

// File: rtl/seg_sel_file.sv
// Selector storage: one write port, one synchronous read port, so the
// array maps onto distributed or block RAM. Per-entry "written" bits
// make unwritten entries read as zero without resetting the array.
module seg_sel_file #(
  parameter int SEL_W   = 16,
  parameter int NUM_SEG = 6,
  localparam int ID_W   = $clog2(NUM_SEG)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en_i,
  input  logic [ID_W-1:0]    wr_id_i,
  input  logic [SEL_W-1:0]   wr_sel_i,
  input  logic               wr_null_i,
  input  logic [ID_W-1:0]    rd_id_i,
  output logic [SEL_W-1:0]   rd_sel_o,
  output logic [NUM_SEG-1:0] null_vec_o
);

  logic [SEL_W-1:0]   mem [NUM_SEG];
  logic [NUM_SEG-1:0] written_q;
  logic [NUM_SEG-1:0] null_q;
  logic [SEL_W-1:0]   rd_q;
  logic               rd_live_q;
  logic               wr_in_range;
  logic               rd_in_range;

  assign wr_in_range = ({1'b0, wr_id_i} < (ID_W+1)'(NUM_SEG));
  assign rd_in_range = ({1'b0, rd_id_i} < (ID_W+1)'(NUM_SEG));

  // Array without reset: RAM-inferable.
  always_ff @(posedge clk) begin
    if (wr_en_i && wr_in_range) begin
      mem[wr_id_i] <= wr_sel_i;
    end
    if (rd_in_range) begin
      rd_q <= mem[rd_id_i];
    end
  end

  // Small flag vectors carry the reset state.
  always_ff @(posedge clk) begin
    if (rst) begin
      written_q <= '0;
      null_q    <= '1;
      rd_live_q <= 1'b0;
    end else begin
      if (wr_en_i && wr_in_range) begin
        written_q[wr_id_i] <= 1'b1;
        null_q[wr_id_i]    <= wr_null_i;
      end
      rd_live_q <= rd_in_range && written_q[rd_id_i];
    end
  end

  assign rd_sel_o   = rd_live_q ? rd_q : '0;
  assign null_vec_o = null_q;

endmodule

// File: rtl/seg_load_check.sv
// Combinational decision for one request.
module seg_load_check
  import seg_pkg::*;
#(
  parameter int SEL_W   = 16,
  parameter int NUM_SEG = 6,
  parameter int RPL_W   = 2,
  localparam int ID_W   = $clog2(NUM_SEG)
) (
  input  logic [1:0]         op_i,
  input  logic [ID_W-1:0]    seg_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               desc_ok_i,
  input  logic [NUM_SEG-1:0] null_vec_i,
  output verdict_t           verdict_o
);

  logic id_ok;
  logic sel_null;
  logic seg_null;
  logic is_cs;
  logic is_ss;

  assign id_ok    = ({1'b0, seg_i} < (ID_W+1)'(NUM_SEG));
  // Null: only the requested-privilege bits may be non-zero.
  assign sel_null = (sel_i[SEL_W-1:RPL_W] == '0);
  assign seg_null = id_ok ? null_vec_i[seg_i] : 1'b1;
  assign is_cs    = (seg_i == ID_W'(SEG_CS));
  assign is_ss    = (seg_i == ID_W'(SEG_SS));

  always_comb begin
    verdict_o = '0;
    unique case (seg_op_e'(op_i))
      OP_LOAD: begin
        if (!id_ok || is_cs) begin
          verdict_o.ud = 1'b1;
        end else if (sel_null) begin
          if (is_ss) begin
            verdict_o.gp = 1'b1;
          end else begin
            verdict_o.commit  = 1'b1;
            verdict_o.is_null = 1'b1;
          end
        end else if (desc_ok_i) begin
          verdict_o.commit    = 1'b1;
          verdict_o.ss_commit = is_ss;
        end else begin
          verdict_o.gp = 1'b1;
        end
      end
      OP_READ: begin
        if (!id_ok) verdict_o.ud = 1'b1;
        else        verdict_o.rd = 1'b1;
      end
      OP_MEM: begin
        if (!id_ok)        verdict_o.ud  = 1'b1;
        else if (seg_null) verdict_o.gp  = 1'b1;
        else               verdict_o.mem = 1'b1;
      end
      default: verdict_o = '0;
    endcase
  end

endmodule

// File: rtl/seg_irq_shadow.sv
// One-instruction interrupt shadow after a committed stack-segment load.
module seg_irq_shadow (
  input  logic clk,
  input  logic rst,
  input  logic retire_i,
  input  logic ss_commit_i,
  input  logic irq_req_i,
  input  logic bkpt_hit_i,
  output logic shadow_o,
  output logic irq_take_o,
  output logic bkpt_take_o
);

  logic shadow_q;
  logic shadow_d;

  // Any retire while open closes it; a load in that slot does not re-arm.
  always_comb begin
    shadow_d = shadow_q;
    if (retire_i) begin
      shadow_d = !shadow_q && ss_commit_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q    <= 1'b0;
      irq_take_o  <= 1'b0;
      bkpt_take_o <= 1'b0;
    end else begin
      shadow_q    <= shadow_d;
      irq_take_o  <= irq_req_i && !shadow_q;
      bkpt_take_o <= bkpt_hit_i && !shadow_q;
    end
  end

  assign shadow_o = shadow_q;

endmodule

// File: rtl/seg_load_unit.sv
module seg_load_unit
  import seg_pkg::*;
#(
  parameter int SEL_W   = 16,
  parameter int GPR_W   = 64,
  parameter int NUM_SEG = 6,
  parameter int RPL_W   = 2,
  localparam int ID_W   = $clog2(NUM_SEG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             retire_i,
  input  logic [1:0]       op_i,
  input  logic [ID_W-1:0]  seg_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             desc_ok_i,
  input  logic             irq_req_i,
  input  logic             bkpt_hit_i,
  output logic             fault_ud_o,
  output logic             fault_gp_o,
  output logic             commit_o,
  output logic             rd_valid_o,
  output logic [GPR_W-1:0] rd_data_o,
  output logic             mem_req_o,
  output logic             irq_take_o,
  output logic             bkpt_take_o,
  output logic             shadow_o
);

  localparam int PAD_W = GPR_W - SEL_W;

  verdict_t           verdict;
  logic [NUM_SEG-1:0] null_vec;
  logic [SEL_W-1:0]   rd_sel;
  logic               wr_en;

  seg_load_check #(
    .SEL_W  (SEL_W),
    .NUM_SEG(NUM_SEG),
    .RPL_W  (RPL_W)
  ) check_i (
    .op_i      (op_i),
    .seg_i     (seg_i),
    .sel_i     (sel_i),
    .desc_ok_i (desc_ok_i),
    .null_vec_i(null_vec),
    .verdict_o (verdict)
  );

  assign wr_en = retire_i && verdict.commit;

  seg_sel_file #(
    .SEL_W  (SEL_W),
    .NUM_SEG(NUM_SEG)
  ) file_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en),
    .wr_id_i   (seg_i),
    .wr_sel_i  (sel_i),
    .wr_null_i (verdict.is_null),
    .rd_id_i   (seg_i),
    .rd_sel_o  (rd_sel),
    .null_vec_o(null_vec)
  );

  seg_irq_shadow shadow_i (
    .clk        (clk),
    .rst        (rst),
    .retire_i   (retire_i),
    .ss_commit_i(verdict.ss_commit),
    .irq_req_i  (irq_req_i),
    .bkpt_hit_i (bkpt_hit_i),
    .shadow_o   (shadow_o),
    .irq_take_o (irq_take_o),
    .bkpt_take_o(bkpt_take_o)
  );

  always_ff @(posedge clk) begin
    if (rst || !retire_i) begin
      fault_ud_o <= 1'b0;
      fault_gp_o <= 1'b0;
      commit_o   <= 1'b0;
      rd_valid_o <= 1'b0;
      mem_req_o  <= 1'b0;
    end else begin
      fault_ud_o <= verdict.ud;
      fault_gp_o <= verdict.gp;
      commit_o   <= verdict.commit;
      rd_valid_o <= verdict.rd;
      mem_req_o  <= verdict.mem;
    end
  end

  // Read data is aligned with rd_valid_o by the file's synchronous read.
  assign rd_data_o = rd_valid_o ? {{PAD_W{1'b0}}, rd_sel} : '0;

endmodule

// File: rtl/seg_load_unit_chk.sv
module seg_load_unit_chk #(
  parameter int SEL_W   = 16,
  parameter int NUM_SEG = 6,
  parameter int RPL_W   = 2,
  localparam int ID_W   = $clog2(NUM_SEG)
) (
  input logic             clk,
  input logic             rst,
  input logic             retire_i,
  input logic [1:0]       op_i,
  input logic [ID_W-1:0]  seg_i,
  input logic [SEL_W-1:0] sel_i,
  input logic             desc_ok_i,
  input logic             fault_ud_o,
  input logic             fault_gp_o,
  input logic             commit_o,
  input logic             rd_valid_o,
  input logic             mem_req_o,
  input logic             irq_take_o,
  input logic             bkpt_take_o,
  input logic             shadow_o
);

  logic ld_req;
  logic ld_null;
  assign ld_req  = retire_i && (op_i == 2'd1);
  assign ld_null = (sel_i[SEL_W-1:RPL_W] == '0);

  assert_onehot_result_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fault_ud_o, fault_gp_o, commit_o, rd_valid_o, mem_req_o}));

  assert_no_idle_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    !$past(retire_i) |->
      !(fault_ud_o || fault_gp_o || commit_o || rd_valid_o || mem_req_o));

  assert_cs_load_ud_R1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ld_req && seg_i == ID_W'(1))) |->
      (fault_ud_o && !commit_o));

  assert_ss_null_gp_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ld_req && seg_i == ID_W'(2) && ld_null)) |->
      (fault_gp_o && !commit_o));

  assert_ss_opens_shadow_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ld_req && seg_i == ID_W'(2) && !ld_null &&
                          desc_ok_i && !shadow_o)) |-> shadow_o);

  assert_shadow_blocks_irq_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(shadow_o)) |-> !irq_take_o);

  assert_shadow_no_chain_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(retire_i && shadow_o)) |-> !shadow_o);

  assert_shadow_blocks_bkpt_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(shadow_o)) |-> !bkpt_take_o);

  assert_reset_closes_shadow_R8: assert property (@(posedge clk)
    $past(rst) |-> !shadow_o);

endmodule

bind seg_load_unit seg_load_unit_chk #(
  .SEL_W  (SEL_W),
  .NUM_SEG(NUM_SEG),
  .RPL_W  (RPL_W)
) chk_i (.*);

// File: tb/seg_load_unit_tb_top.sv
`timescale 1ns/1ps
module seg_load_unit_tb_top;

  localparam real HALF = 2.5;  // 200 MHz

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        retire_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [2:0]  seg_i = '0;
  logic [15:0] sel_i = '0;
  logic        desc_ok_i = 1'b0;
  logic        irq_req_i = 1'b0;
  logic        bkpt_hit_i = 1'b0;
  logic        fault_ud_o, fault_gp_o, commit_o, rd_valid_o, mem_req_o;
  logic        irq_take_o, bkpt_take_o, shadow_o;
  logic [63:0] rd_data_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #HALF clk = ~clk;

  seg_load_unit dut_i (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [63:0] act,
                        input logic [63:0] exp);
    check(act === exp, req, act, exp);
  endtask

  // Result bits {ud,gp,commit,rd,mem} captured after the retire edge.
  logic [4:0]  res;
  logic [63:0] rdat;

  task automatic do_op(input logic [1:0] op, input logic [2:0] seg,
                       input logic [15:0] sel, input logic ok);
    @(negedge clk);
    retire_i = 1'b1; op_i = op; seg_i = seg; sel_i = sel; desc_ok_i = ok;
    @(negedge clk);
    res  = {fault_ud_o, fault_gp_o, commit_o, rd_valid_o, mem_req_o};
    rdat = rd_data_o;
    retire_i = 1'b0; op_i = 2'd0;
  endtask

  function automatic logic [63:0] read_seg_val();
    return rdat;
  endfunction

  task automatic t_reset_state();
    for (int s = 0; s < 6; s++) begin
      do_op(2'd2, 3'(s), 16'h0, 1'b0);
      chk_eq("R8 read valid after reset", 64'(res), 64'b00010);
      chk_eq("R8 selector zero after reset", rdat, 64'h0);
    end
    do_op(2'd3, 3'd3, 16'h0, 1'b0);
    chk_eq("R8 null flag set: DS mem ref faults", 64'(res), 64'b01000);
    chk_eq("R8 shadow closed", 64'(shadow_o), 64'h0);
  endtask

  task automatic t_cs_load();
    do_op(2'd1, 3'd1, 16'h0123, 1'b1);
    chk_eq("R1 CS load gives ud only", 64'(res), 64'b10000);
    do_op(2'd2, 3'd1, 16'h0, 1'b0);
    chk_eq("R1 CS unchanged", rdat, 64'h0);
  endtask

  task automatic t_bad_id();
    do_op(2'd1, 3'd6, 16'h0040, 1'b1);
    chk_eq("R2 load id6 ud", 64'(res), 64'b10000);
    do_op(2'd2, 3'd7, 16'h0, 1'b0);
    chk_eq("R2 read id7 ud", 64'(res), 64'b10000);
    do_op(2'd3, 3'd6, 16'h0, 1'b0);
    chk_eq("R2 mem id6 ud", 64'(res), 64'b10000);
  endtask

  task automatic t_data_loads();
    do_op(2'd1, 3'd3, 16'h5678, 1'b1);
    chk_eq("R5 DS non-null commit", 64'(res), 64'b00100);
    do_op(2'd3, 3'd3, 16'h0, 1'b0);
    chk_eq("R6 DS mem ref allowed", 64'(res), 64'b00001);
    do_op(2'd1, 3'd3, 16'h9ab8, 1'b0);
    chk_eq("R5 bad descriptor gp", 64'(res), 64'b01000);
    do_op(2'd2, 3'd3, 16'h0, 1'b0);
    chk_eq("R5 DS keeps old selector", rdat, 64'h5678);
    chk_eq("R7 rd valid", 64'(res), 64'b00010);
    do_op(2'd1, 3'd4, 16'hfff7, 1'b1);
    do_op(2'd2, 3'd4, 16'h0, 1'b0);
    chk_eq("R7 zero-extended FS", rdat, 64'h0000_0000_0000_fff7);
    // null boundary
    do_op(2'd1, 3'd3, 16'h0003, 1'b0);
    chk_eq("R3 null 0x0003 commits without fault", 64'(res), 64'b00100);
    do_op(2'd3, 3'd3, 16'h0, 1'b0);
    chk_eq("R6 null DS mem ref gp, no req", 64'(res), 64'b01000);
    do_op(2'd1, 3'd5, 16'h0004, 1'b1);
    chk_eq("R3 0x0004 non-null commit", 64'(res), 64'b00100);
    do_op(2'd3, 3'd5, 16'h0, 1'b0);
    chk_eq("R3 0x0004 not null: mem ok", 64'(res), 64'b00001);
    do_op(2'd1, 3'd5, 16'h0004, 1'b0);
    chk_eq("R3 0x0004 needs descriptor", 64'(res), 64'b01000);
    do_op(2'd1, 3'd0, 16'h0000, 1'b0);
    chk_eq("R3 ES null commit", 64'(res), 64'b00100);
  endtask

  task automatic t_ss_null();
    do_op(2'd1, 3'd2, 16'h0030, 1'b1);
    do_op(2'd2, 3'd0, 16'h0, 1'b0);   // retire closes the shadow
    do_op(2'd1, 3'd2, 16'h0002, 1'b1);
    chk_eq("R4 null SS gp", 64'(res), 64'b01000);
    chk_eq("R4 no shadow on fault", 64'(shadow_o), 64'h0);
    do_op(2'd2, 3'd2, 16'h0, 1'b0);
    chk_eq("R4 SS keeps selector", rdat, 64'h0030);
  endtask

  task automatic t_shadow_chain();
    @(negedge clk);
    irq_req_i = 1'b1;
    retire_i = 1'b1; op_i = 2'd1; seg_i = 3'd2; sel_i = 16'h0048; desc_ok_i = 1'b1;
    @(negedge clk);
    chk_eq("R9 shadow opens", 64'(shadow_o), 64'h1);
    chk_eq("R9 irq taken before load", 64'(irq_take_o), 64'h1);
    retire_i = 1'b0; op_i = 2'd0;
    @(negedge clk);
    chk_eq("R9 irq blocked in shadow", 64'(irq_take_o), 64'h0);
    retire_i = 1'b1; op_i = 2'd1; seg_i = 3'd2; sel_i = 16'h0050;
    @(negedge clk);
    chk_eq("R10 second SS load commits", 64'(commit_o), 64'h1);
    chk_eq("R10 shadow not re-armed", 64'(shadow_o), 64'h0);
    chk_eq("R9 irq still blocked", 64'(irq_take_o), 64'h0);
    retire_i = 1'b0; op_i = 2'd0;
    @(negedge clk);
    chk_eq("R10 irq taken before third", 64'(irq_take_o), 64'h1);
    irq_req_i = 1'b0;
  endtask

  task automatic t_bkpt();
    do_op(2'd1, 3'd2, 16'h0058, 1'b1);
    chk_eq("R9 SS load opens shadow", 64'(shadow_o), 64'h1);
    @(negedge clk);
    bkpt_hit_i = 1'b1;
    @(negedge clk);
    chk_eq("R11 breakpoint ignored in shadow", 64'(bkpt_take_o), 64'h0);
    do_op(2'd0, 3'd0, 16'h0, 1'b0);
    chk_eq("R9 next retire closes shadow", 64'(shadow_o), 64'h0);
    chk_eq("R12 no result for op 0", 64'(res), 64'h0);
    @(negedge clk);
    chk_eq("R11 breakpoint taken after shadow", 64'(bkpt_take_o), 64'h1);
    bkpt_hit_i = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_cs_load();
    t_bad_id();
    t_data_loads();
    t_ss_null();
    t_shadow_chain();
    t_bkpt();
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(2.0 * HALF * 20000.0);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule